// File: doc/BRIEF.md
# Translation-Buffer Load Assist Register Block

This block holds the special registers that a software page-table walk uses to fill a 32-entry translation buffer. When the lookup logic reports a miss, the block captures the faulting page number. The address-space ID comes from a context register. Software then reads two walk-base registers. Each read returns a computed descriptor address rather than the stored value. The first returns the first-level table base with the upper page-number bits inserted as a word index. The second returns the second-level table base with the middle page-number bits inserted as a word index.

Once software has the descriptor, it writes the real page number. That single write commits a whole buffer entry in one cycle. The entry is built from the written value, the captured page-number register and the level-one control register. The buffer position comes from an index field in the control register. The index then advances on its own. It can skip a reserved group of low entries when it wraps. The lookup array and the exception logic lie outside this block.

Top module: `walk_assist_regs`

## Requirements
- R1: After reset, the control register (select 0) reads 0x04000000 and `ld_valid` is low.
- R2: The page register (select 2) stores bits [31:12] as page number, bit 9 as entry-valid and bits [3:0] as ASID. All other bits read zero.
- R3: A `miss_valid` cycle loads `miss_epn` into page bits [31:12] and clears bit 9. It loads the ASID from the context register (select 1, bits [3:0]). In the same cycle, a miss wins over a software write to the page register.
- R4: Reading the first-level base register (select 3) returns its stored bits [31:12], with page bits [31:22] in bits [11:2] and 0 in bits [1:0].
- R5: The level-one register (select 4) stores a second-level base in [31:12], a protection group in [8:5], a guarded bit at 4, a page size in [3:2] (00 = 4K/16K, 01 = 512K, 11 = 8M) and a segment-valid bit at 0. A read returns the base with page bits [21:12] in bits [11:2] and zero in bits [1:0].
- R6: A write to the real-page register (select 5) raises `ld_valid` for exactly the following cycle. The `ld_*` fields then carry the written value, the index, and the page and level-one fields held at the time of the write.
- R7: Each entry load increments the index in control bits [12:8]. It wraps from 31 to 0 when control bit 27 is clear.
- R8: When control bit 27 (reserve) is set, the index wraps from 31 to 4.
- R9: A control write sets the index [12:8], the reserve bit 27 and the assist bit 26. A read returns only those bits. All register writes become visible in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Translation miss capture strobe |
| miss_epn | input | 20 | Faulting effective page number |
| sr_wr | input | 1 | Special-register write strobe |
| sr_sel | input | 3 | Register select |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data for `sr_sel` (combinational) |
| ld_valid | output | 1 | Entry-load pulse |
| ld_index | output | 5 | Buffer entry to load |
| ld_epn | output | 20 | Entry page number |
| ld_evalid | output | 1 | Entry valid bit |
| ld_asid | output | 4 | Entry ASID |
| ld_apg | output | 4 | Access protection group |
| ld_guard | output | 1 | Guarded attribute |
| ld_psize | output | 2 | Page-size code |
| ld_svalid | output | 1 | Segment valid |
| ld_rpn | output | 32 | Written real-page word |

## Verification
The bench runs the index through both wrap points. If the reserve wrap is wrong, the index returns to 0 and overwrites a protected entry. If the plain wrap is wrong, the index lands at 4 or runs past 31. It sweeps page numbers through both computed reads. A swapped or shifted index field then shows up as a wrong descriptor address. It also drives a miss and a software page write together. If the wrong source wins, the captured fault is lost.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAGE_W = 20;
  localparam int unsigned ASID_W = 4;
  localparam int unsigned IDX_LSB = 8;
  localparam int unsigned RSV_BIT = 27;
  localparam int unsigned ASSIST_BIT = 26;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0400_0000;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_CTX  = 3'd1,
    SEL_PAGE = 3'd2,
    SEL_L1B  = 3'd3,
    SEL_SEG  = 3'd4,
    SEL_RPN  = 3'd5
  } sel_e;
endpackage

// File: rtl/wa_index_ctr.sv
module wa_index_ctr #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned RSV_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_val,
  input  logic             step,
  input  logic             rsv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_RSV = IDX_W'(RSV_CNT);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = set_en | step;
    idx_d  = idx;
    if (set_en)            idx_d = set_val;
    else if (idx == IDX_MAX) idx_d = rsv ? IDX_RSV : '0;
    else                   idx_d = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end
endmodule

// File: rtl/wa_read_mux.sv
module wa_read_mux
  import wa_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  sel_e              sel,
  input  logic              rsv,
  input  logic              assist,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ASID_W-1:0] ctx_asid,
  input  logic [PAGE_W-1:0] pg_epn,
  input  logic              pg_valid,
  input  logic [ASID_W-1:0] pg_asid,
  input  logic [PAGE_W-1:0] l1_base,
  input  logic [PAGE_W-1:0] l2_base,
  input  logic [WORD_W-1:0] rpn_q,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned SLICE = PAGE_W / 2;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata[RSV_BIT]              = rsv;
        rdata[ASSIST_BIT]           = assist;
        rdata[IDX_LSB +: IDX_W]     = idx;
      end
      SEL_CTX:  rdata[ASID_W-1:0]   = ctx_asid;
      SEL_PAGE: begin
        rdata[WORD_W-1 -: PAGE_W]   = pg_epn;
        rdata[9]                    = pg_valid;
        rdata[ASID_W-1:0]           = pg_asid;
      end
      SEL_L1B:  rdata = {l1_base, pg_epn[PAGE_W-1 -: SLICE], 2'b00};
      SEL_SEG:  rdata = {l2_base, pg_epn[SLICE-1:0], 2'b00};
      SEL_RPN:  rdata = rpn_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wa_entry_out.sv
module wa_entry_out
  import wa_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PAGE_W-1:0] pg_epn,
  input  logic              pg_valid,
  input  logic [ASID_W-1:0] pg_asid,
  input  logic [3:0]        apg,
  input  logic              guard,
  input  logic [1:0]        psize,
  input  logic              svalid,
  input  logic [WORD_W-1:0] rpn,
  output logic              ld_valid,
  output logic [IDX_W-1:0]  ld_index,
  output logic [PAGE_W-1:0] ld_epn,
  output logic              ld_evalid,
  output logic [ASID_W-1:0] ld_asid,
  output logic [3:0]        ld_apg,
  output logic              ld_guard,
  output logic [1:0]        ld_psize,
  output logic              ld_svalid,
  output logic [WORD_W-1:0] ld_rpn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_valid <= 1'b0;
    else        ld_valid <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_index <= '0; ld_epn <= '0; ld_evalid <= 1'b0; ld_asid <= '0;
      ld_apg <= '0; ld_guard <= 1'b0; ld_psize <= '0; ld_svalid <= 1'b0;
      ld_rpn <= '0;
    end else if (fire) begin
      ld_index <= idx; ld_epn <= pg_epn; ld_evalid <= pg_valid;
      ld_asid <= pg_asid; ld_apg <= apg; ld_guard <= guard;
      ld_psize <= psize; ld_svalid <= svalid; ld_rpn <= rpn;
    end
  end
endmodule

// File: rtl/walk_assist_regs.sv
module walk_assist_regs
  import wa_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned RSV_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [PAGE_W-1:0] miss_epn,
  input  logic              sr_wr,
  input  logic [2:0]        sr_sel,
  input  logic [WORD_W-1:0] sr_wdata,
  output logic [WORD_W-1:0] sr_rdata,
  output logic              ld_valid,
  output logic [IDX_W-1:0]  ld_index,
  output logic [PAGE_W-1:0] ld_epn,
  output logic              ld_evalid,
  output logic [ASID_W-1:0] ld_asid,
  output logic [3:0]        ld_apg,
  output logic              ld_guard,
  output logic [1:0]        ld_psize,
  output logic              ld_svalid,
  output logic [WORD_W-1:0] ld_rpn
);
  sel_e sel;
  assign sel = sel_e'(sr_sel);

  logic wr_ctrl, wr_ctx, wr_page, wr_l1b, wr_seg, wr_rpn;
  always_comb begin
    wr_ctrl = sr_wr && (sel == SEL_CTRL);
    wr_ctx  = sr_wr && (sel == SEL_CTX);
    wr_page = sr_wr && (sel == SEL_PAGE);
    wr_l1b  = sr_wr && (sel == SEL_L1B);
    wr_seg  = sr_wr && (sel == SEL_SEG);
    wr_rpn  = sr_wr && (sel == SEL_RPN);
  end

  logic              ctrl_rsv, ctrl_assist;
  logic [IDX_W-1:0]  cur_idx;
  logic [ASID_W-1:0] ctx_asid;
  logic [PAGE_W-1:0] pg_epn, pg_epn_d;
  logic              pg_valid, pg_valid_d;
  logic [ASID_W-1:0] pg_asid, pg_asid_d;
  logic              pg_en;
  logic [PAGE_W-1:0] l1_base, l2_base;
  logic [3:0]        seg_apg;
  logic              seg_guard, seg_svalid;
  logic [1:0]        seg_psize;
  logic [WORD_W-1:0] rpn_q;

  // Page register next state: a miss outranks a software write
  always_comb begin
    pg_en      = miss_valid | wr_page;
    pg_epn_d   = sr_wdata[WORD_W-1 -: PAGE_W];
    pg_valid_d = sr_wdata[9];
    pg_asid_d  = sr_wdata[ASID_W-1:0];
    if (miss_valid) begin
      pg_epn_d   = miss_epn;
      pg_valid_d = 1'b0;
      pg_asid_d  = ctx_asid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_rsv    <= CTRL_RESET[RSV_BIT];
      ctrl_assist <= CTRL_RESET[ASSIST_BIT];
    end else if (wr_ctrl) begin
      ctrl_rsv    <= sr_wdata[RSV_BIT];
      ctrl_assist <= sr_wdata[ASSIST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_asid <= '0;
    else if (wr_ctx) ctx_asid <= sr_wdata[ASID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_epn <= '0; pg_valid <= 1'b0; pg_asid <= '0;
    end else if (pg_en) begin
      pg_epn <= pg_epn_d; pg_valid <= pg_valid_d; pg_asid <= pg_asid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      l1_base <= '0;
    else if (wr_l1b) l1_base <= sr_wdata[WORD_W-1 -: PAGE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_base <= '0; seg_apg <= '0; seg_guard <= 1'b0;
      seg_psize <= '0; seg_svalid <= 1'b0;
    end else if (wr_seg) begin
      l2_base    <= sr_wdata[WORD_W-1 -: PAGE_W];
      seg_apg    <= sr_wdata[8:5];
      seg_guard  <= sr_wdata[4];
      seg_psize  <= sr_wdata[3:2];
      seg_svalid <= sr_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rpn_q <= '0;
    else if (wr_rpn) rpn_q <= sr_wdata;
  end

  wa_index_ctr #(.IDX_W(IDX_W), .RSV_CNT(RSV_CNT)) u_idx (
    .clk(clk), .rst_n(rst_n), .set_en(wr_ctrl),
    .set_val(sr_wdata[IDX_LSB +: IDX_W]), .step(wr_rpn),
    .rsv(ctrl_rsv), .idx(cur_idx)
  );

  wa_read_mux #(.IDX_W(IDX_W)) u_rd (
    .sel(sel), .rsv(ctrl_rsv), .assist(ctrl_assist), .idx(cur_idx),
    .ctx_asid(ctx_asid), .pg_epn(pg_epn), .pg_valid(pg_valid),
    .pg_asid(pg_asid), .l1_base(l1_base), .l2_base(l2_base),
    .rpn_q(rpn_q), .rdata(sr_rdata)
  );

  wa_entry_out #(.IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(wr_rpn), .idx(cur_idx),
    .pg_epn(pg_epn), .pg_valid(pg_valid), .pg_asid(pg_asid),
    .apg(seg_apg), .guard(seg_guard), .psize(seg_psize),
    .svalid(seg_svalid), .rpn(sr_wdata),
    .ld_valid(ld_valid), .ld_index(ld_index), .ld_epn(ld_epn),
    .ld_evalid(ld_evalid), .ld_asid(ld_asid), .ld_apg(ld_apg),
    .ld_guard(ld_guard), .ld_psize(ld_psize), .ld_svalid(ld_svalid),
    .ld_rpn(ld_rpn)
  );
endmodule

// File: rtl/wa_regs_chk.sv
module wa_regs_chk #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned RSV_CNT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic [19:0]      miss_epn,
  input logic             sr_wr,
  input logic [2:0]       sr_sel,
  input logic [31:0]      sr_wdata,
  input logic             ld_valid,
  input logic [IDX_W-1:0] ld_index,
  input logic [31:0]      ld_rpn,
  input logic [IDX_W-1:0] cur_idx,
  input logic             ctrl_rsv,
  input logic [19:0]      pg_epn
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  logic rpn_wr;
  assign rpn_wr = sr_wr && (sr_sel == 3'd5);

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rpn_wr |=> ld_valid) else $error("load pulse missing"); // R6
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rpn_wr |=> !ld_valid) else $error("spurious load"); // R6
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rpn_wr |=> ld_rpn == $past(sr_wdata)) else $error("load data"); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_index != IDX_MAX |-> cur_idx == ld_index + 1'b1)
    else $error("index step"); // R7
  AST_IDX_WRAP_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_index == IDX_MAX && ctrl_rsv |-> cur_idx == IDX_W'(RSV_CNT))
    else $error("reserve wrap"); // R8
  AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> pg_epn == $past(miss_epn)) else $error("miss capture"); // R3
endmodule

bind walk_assist_regs wa_regs_chk #(.IDX_W(IDX_W), .RSV_CNT(RSV_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_epn(miss_epn),
  .sr_wr(sr_wr), .sr_sel(sr_sel), .sr_wdata(sr_wdata), .ld_valid(ld_valid),
  .ld_index(ld_index), .ld_rpn(ld_rpn), .cur_idx(cur_idx),
  .ctrl_rsv(ctrl_rsv), .pg_epn(pg_epn)
);

// File: tb/tb_walk_assist_regs.sv
module tb_walk_assist_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [19:0] miss_epn = '0;
  logic        sr_wr = 1'b0;
  logic [2:0]  sr_sel = '0;
  logic [31:0] sr_wdata = '0;
  logic [31:0] sr_rdata;
  logic        ld_valid, ld_evalid, ld_guard, ld_svalid;
  logic [4:0]  ld_index;
  logic [19:0] ld_epn;
  logic [3:0]  ld_asid, ld_apg;
  logic [1:0]  ld_psize;
  logic [31:0] ld_rpn;

  int checks = 0, fails = 0;
  logic [4:0] idx_m;
  logic rsv_m;

  walk_assist_regs dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    @(negedge clk); sr_wr = 1'b1; sr_sel = s; sr_wdata = d;
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] s, output logic [31:0] d);
    sr_sel = s; #1; d = sr_rdata;
  endtask

  // one entry load with full field checks, expected page fields given
  task automatic do_load(logic [31:0] rpn, logic [31:0] pg, logic [31:0] seg);
    wr(3'd5, rpn);
    chk("R6 ld_valid", {31'b0, ld_valid}, 32'd1);
    chk("R6 ld_index", {27'b0, ld_index}, {27'b0, idx_m});
    chk("R6 ld_rpn", ld_rpn, rpn);
    chk("R6 ld_page", {ld_epn, 2'b0, ld_evalid, 5'b0, ld_asid}, pg & 32'hFFFF_F20F);
    chk("R6 ld_seg", {23'b0, ld_apg, ld_guard, ld_psize, 1'b0, ld_svalid},
        seg & 32'h0000_01FD);
    if (idx_m == 5'd31) idx_m = rsv_m ? 5'd4 : 5'd0;
    else idx_m = idx_m + 5'd1;
    @(negedge clk);
    chk("R6 single pulse", {31'b0, ld_valid}, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    #(CLK_PERIOD*3) @(negedge clk); rst_n = 1'b1;

    rd(3'd0, v); chk("R1 ctrl reset", v, 32'h0400_0000);
    chk("R1 ld_valid reset", {31'b0, ld_valid}, 32'd0);

    wr(3'd1, 32'hFFFF_FFF9); rd(3'd1, v); chk("R3 ctx reg", v, 32'h9);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R2 page all ones", v, 32'hFFFF_F20F);
    wr(3'd2, 32'h1234_5DF0); rd(3'd2, v); chk("R2 page pattern", v, 32'h1234_5000);

    // miss capture, then miss colliding with software write
    @(negedge clk); miss_valid = 1'b1; miss_epn = 20'hABCDE;
    @(negedge clk); miss_valid = 1'b0;
    rd(3'd2, v); chk("R3 miss capture", v, 32'hABCD_E009);
    wr(3'd2, 32'hFFFF_F200);
    @(negedge clk); miss_valid = 1'b1; miss_epn = 20'h13579;
    sr_wr = 1'b1; sr_sel = 3'd2; sr_wdata = 32'h2468_A20F;
    @(negedge clk); miss_valid = 1'b0; sr_wr = 1'b0;
    rd(3'd2, v); chk("R3 miss beats write", v, 32'h1357_9009);

    // sweep of computed descriptor addresses
    wr(3'd3, 32'hA5A5_AFFF);
    wr(3'd4, 32'h5A5A_5FFF);
    for (int k = 0; k < 24; k++) begin
      logic [31:0] pg;
      pg = (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << (k + 8));
      wr(3'd2, pg);
      rd(3'd3, v); chk("R4 first-level addr", v, 32'hA5A5_A000 | ((pg >> 22) << 2));
      rd(3'd4, v); chk("R5 second-level addr", v, 32'h5A5A_5000 | (((pg >> 12) & 32'h3FF) << 2));
    end

    // loads: plain wrap
    rsv_m = 1'b0; idx_m = 5'd28;
    wr(3'd0, 32'h0400_1C00); rd(3'd0, v); chk("R9 ctrl write", v, 32'h0400_1C00);
    wr(3'd2, 32'hCAFE_B203);
    wr(3'd4, 32'h0001_01AD);
    for (int k = 0; k < 5; k++) do_load(32'h1000_0000 + k, 32'hCAFE_B203, 32'h0001_01AD);
    rd(3'd0, v); chk("R7 wrap to zero", v, 32'h0400_0100);

    // loads: reserve wrap, page size 8M, no guard
    rsv_m = 1'b1; idx_m = 5'd30;
    wr(3'd0, 32'h0C00_1E00); rd(3'd0, v); chk("R9 ctrl reserve", v, 32'h0C00_1E00);
    wr(3'd4, 32'h0002_016D);
    for (int k = 0; k < 4; k++) do_load(32'hBEEF_0000 ^ k, 32'hCAFE_B203, 32'h0002_016D);
    rd(3'd0, v); chk("R8 reserve wrap", v, 32'h0C00_0600);

    // full lap with reserve set: index never drops below 4
    for (int k = 0; k < 28; k++) do_load(32'h77 + k, 32'hCAFE_B203, 32'h0002_016D);
    rd(3'd0, v); chk("R8 full lap", v, 32'h0C00_0600);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule